// File: doc/BRIEF.md
# Embedded word-boundary deserializer

This block turns a serial data line and its forwarded serial clock back into 24-bit parallel words. The transmitter marks the end of every word by holding the serial clock high for much longer than a normal high half-period. Each frame carries 26 bits: 24 payload bits, sent least significant first, followed by two boundary bits. The first boundary bit is the complement of payload bit 24 and the second equals it, so the data line toggles while the clock is held high.

Both serial lines are oversampled by a local clock that runs at least eight times the bit rate, after a two-flop synchronizer. A data bit is taken on every rising edge of the synchronized serial clock. The length of each high phase is counted in local-clock cycles. When a high phase that exceeded the threshold ends, the collected frame is judged. If the bit count and both boundary bits are correct, the 24 payload bits are latched for the parallel port and a one-cycle strobe is raised. If not, the word is dropped and an error pulse is raised. Either way, the next rising edge begins a new frame. The parallel port drives only while the direction input is low.

Top module: `ewb_deser`

## Requirements
- R1: While reset is held and right after it, word_valid_o, len_err_o and bnd_err_o are 0 and the held word is 0. With dir_i low, par_o therefore reads 0.
- R2: The payload bit sampled on the first rising serial-clock edge of a frame becomes par_o[0], and the bit sampled on the 24th edge becomes par_o[23].
- R3: A serial-clock high phase lasting more than HI_LIMIT local-clock cycles (default 16) is a boundary. A high phase of exactly HI_LIMIT cycles is an ordinary bit.
- R4: word_valid_o pulses for exactly one local-clock cycle. It is raised in the third local-clock cycle after the serial clock falls at the end of a boundary, and is still 0 in the second.
- R5: par_o carries only the 24 payload bits. The two boundary bits never appear on it.
- R6: If a boundary ends after a number of rising edges other than 26, len_err_o pulses at the time R4 gives for word_valid_o. No strobe follows and par_o keeps the previous word.
- R7: For a 26-bit frame where bit 25 is not the complement of bit 24, or bit 26 does not equal bit 24, bnd_err_o pulses at the R4 time. No strobe follows and par_o keeps the previous word.
- R8: A correct frame sent right after a frame that raised an error is received normally.
- R9: After reset, the frame that ends at the first boundary produces neither a strobe nor an error, whatever its length.
- R10: While dir_i is 1, par_oe_o is 0 and par_o is high-impedance. While dir_i is 0, par_oe_o is 1 and par_o shows the held word, including a word captured while dir_i was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oversampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk_i | input | 1 | Forwarded serial clock with stretched high phase at each word end |
| ser_dat_i | input | 1 | Serial data, sampled on serial-clock rising edges |
| dir_i | input | 1 | Direction: 0 drives the parallel port, 1 releases it |
| par_o | output | 24 | Parallel word, high-impedance while dir_i is 1 |
| par_oe_o | output | 1 | 1 while the parallel port is driven |
| word_valid_o | output | 1 | One-cycle strobe when a new word is latched |
| len_err_o | output | 1 | One-cycle pulse: boundary arrived with a wrong bit count |
| bnd_err_o | output | 1 | One-cycle pulse: boundary bits inconsistent with bit 24 |

## Verification
Every frame result is due three local-clock edges after the serial clock falls at the end of the stretched high phase. Two of those edges are spent in the synchronizer and one in the output register. The bench drives the serial lines on falling local-clock edges and counts falling edges from that final serial-clock fall. It checks that the strobe is still low at the second falling edge, and at the third it compares the strobe, both error pulses and the parallel word. The direction output follows dir_i with no register, so it is checked one falling edge after dir_i changes.

// File: rtl/ewb_pkg.sv
// Package: types and helpers shared by the embedded word-boundary deserializer.
// Assumes nothing beyond the frame layout: payload, then two boundary bits.
package ewb_pkg;

    // Per-cycle events produced by the serial-clock timer.
    typedef struct packed {
        logic rise;     // synchronized serial clock rose this cycle
        logic bnd_end;  // over-long high phase ended this cycle
    } ewb_evt_t;

    // Expected boundary pair {bit26, bit25} for a given payload bit 24.
    function automatic logic [1:0] bnd_pair(input logic last_bit);
        return {last_bit, ~last_bit};
    endfunction

endpackage

// File: rtl/ewb_sync.sv
// Module: multi-stage synchronizer for a bundle of asynchronous inputs.
// Assumes each input is a level that stays stable for several local clocks.
module ewb_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    // Shift the raw inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/ewb_edge_timer.sv
// Module: finds rising edges of the synchronized serial clock and times
// each high phase in local-clock cycles. A high phase longer than HI_LIMIT
// cycles marks a word boundary, reported in the cycle it ends.
// Assumes the input is already synchronized to clk.
module ewb_edge_timer
    import ewb_pkg::*;
#(
    parameter int HI_LIMIT = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sclk,
    output ewb_evt_t evt
);
    localparam int CW = $clog2(HI_LIMIT + 2);
    localparam logic [CW-1:0] CNT_SAT = CW'(HI_LIMIT + 1);
    localparam logic [CW-1:0] CNT_LIM = CW'(HI_LIMIT);

    logic          sclk_q;
    logic [CW-1:0] hi_cnt;
    logic          rise;
    logic          fall;

    assign rise = sclk & ~sclk_q;
    assign fall = ~sclk & sclk_q;

    // Remember the previous level and count high cycles, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            hi_cnt <= '0;
        end else begin
            sclk_q <= sclk;
            if (rise) begin
                hi_cnt <= CW'(1);
            end else if (sclk && hi_cnt != CNT_SAT) begin
                hi_cnt <= hi_cnt + CW'(1);
            end
        end
    end

    assign evt.rise    = rise;
    assign evt.bnd_end = fall && (hi_cnt > CNT_LIM);
endmodule

// File: rtl/ewb_framer.sv
// Module: shifts data bits in on serial-clock rising edges, LSB first,
// counts them, and judges the frame when a boundary ends. A good frame
// updates the held word and strobes valid. A bad length or bad boundary
// bits give an error pulse and leave the word alone. The frame that ends
// at the first boundary after reset only establishes alignment.
// Assumes rise and bnd_end are never high in the same cycle.
module ewb_framer
    import ewb_pkg::*;
#(
    parameter int DATA_W    = 24,
    parameter bit CHECK_BND = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ewb_evt_t          evt,
    input  logic              dat,
    output logic [DATA_W-1:0] word_q,
    output logic              valid_q,
    output logic              len_err_q,
    output logic              bnd_err_q
);
    localparam int FW  = DATA_W + 2;
    localparam int BCW = $clog2(FW + 2);
    localparam logic [BCW-1:0] BC_FULL = BCW'(FW);
    localparam logic [BCW-1:0] BC_SAT  = BCW'(FW + 1);

    logic [FW-1:0]  sr;
    logic [BCW-1:0] bcnt;
    logic           locked;
    logic           len_ok;
    logic           bnd_ok;

    assign len_ok = (bcnt == BC_FULL);

    generate
        if (CHECK_BND) begin : g_chk
            assign bnd_ok = (sr[FW-1:FW-2] == bnd_pair(sr[FW-3]));
        end else begin : g_nochk
            assign bnd_ok = 1'b1;
        end
    endgenerate

    // Collect bits on rising edges and restart the count at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr   <= '0;
            bcnt <= '0;
        end else if (evt.bnd_end) begin
            bcnt <= '0;
        end else if (evt.rise) begin
            sr <= {dat, sr[FW-1:1]};
            if (bcnt != BC_SAT) begin
                bcnt <= bcnt + BCW'(1);
            end
        end
    end

    // Judge the frame at the end of each boundary and drive the results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked    <= 1'b0;
            word_q    <= '0;
            valid_q   <= 1'b0;
            len_err_q <= 1'b0;
            bnd_err_q <= 1'b0;
        end else begin
            valid_q   <= 1'b0;
            len_err_q <= 1'b0;
            bnd_err_q <= 1'b0;
            if (evt.bnd_end) begin
                locked <= 1'b1;
                if (locked) begin
                    if (!len_ok) begin
                        len_err_q <= 1'b1;
                    end else if (!bnd_ok) begin
                        bnd_err_q <= 1'b1;
                    end else begin
                        word_q  <= sr[DATA_W-1:0];
                        valid_q <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/ewb_deser.sv
// Module: top of the embedded word-boundary deserializer. It synchronizes
// the serial lines, times the serial clock, frames and checks words, and
// drives the parallel port under direction control.
// Assumes clk runs at least 8x the bit rate and HI_LIMIT lies between the
// normal high half-period and the stretched boundary high phase.
module ewb_deser #(
    parameter int DATA_W    = 24,
    parameter int HI_LIMIT  = 16,
    parameter int SYNC_STG  = 2,
    parameter bit CHECK_BND = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk_i,
    input  logic              ser_dat_i,
    input  logic              dir_i,
    output logic [DATA_W-1:0] par_o,
    output logic              par_oe_o,
    output logic              word_valid_o,
    output logic              len_err_o,
    output logic              bnd_err_o
);
    import ewb_pkg::*;

    logic [1:0]        sync_q;
    ewb_evt_t          evt;
    logic              bnd_end;
    logic [DATA_W-1:0] word_q;

    ewb_sync #(.W(2), .STAGES(SYNC_STG)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ser_dat_i, ser_clk_i}),
        .q     (sync_q)
    );

    ewb_edge_timer #(.HI_LIMIT(HI_LIMIT)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .sclk  (sync_q[0]),
        .evt   (evt)
    );

    ewb_framer #(.DATA_W(DATA_W), .CHECK_BND(CHECK_BND)) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt),
        .dat       (sync_q[1]),
        .word_q    (word_q),
        .valid_q   (word_valid_o),
        .len_err_q (len_err_o),
        .bnd_err_q (bnd_err_o)
    );

    assign bnd_end  = evt.bnd_end;
    assign par_oe_o = ~dir_i;
    assign par_o    = dir_i ? {DATA_W{1'bz}} : word_q;
endmodule

// File: rtl/ewb_deser_chk.sv
// Module: assertion checker for ewb_deser, attached through bind.
// Assumes it sees the top's boundary event and held word.
module ewb_deser_chk #(
    parameter int DATA_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bnd_end,
    input logic              word_valid_o,
    input logic              len_err_o,
    input logic              bnd_err_o,
    input logic [DATA_W-1:0] word_q
);
    // R4: a strobe follows a boundary end by one cycle.
    p_valid_after_bnd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |-> $past(bnd_end));

    // R4: the strobe lasts one cycle.
    p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |=> !word_valid_o);

    // R6: the held word changes only together with the strobe.
    p_word_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid_o |-> $stable(word_q));

    // R6: a length error follows a boundary end.
    p_len_err_after_bnd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        len_err_o |-> $past(bnd_end));

    // R7: a boundary-bit error follows a boundary end.
    p_bnd_err_after_bnd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bnd_err_o |-> $past(bnd_end));

    // R7: a strobe never comes with an error pulse.
    p_valid_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |-> (!len_err_o && !bnd_err_o));
endmodule

bind ewb_deser ewb_deser_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bnd_end      (bnd_end),
    .word_valid_o (word_valid_o),
    .len_err_o    (len_err_o),
    .bnd_err_o    (bnd_err_o),
    .word_q       (word_q)
);

// File: tb/tb_ewb_deser.sv
`timescale 1ns/1ps
module tb_ewb_deser;
    localparam int LO   = 4;
    localparam int HI   = 4;
    localparam int LONG = 24;
    localparam int LIM  = 16;

    typedef struct packed {
        logic [23:0] data;
        logic [4:0]  nbits;
        logic        bad;
        logic        e_valid;
        logic        e_len;
        logic        e_bnd;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{24'hFFFFFF, 5'd26, 1'b0, 1'b1, 1'b0, 1'b0},
        '{24'h555555, 5'd26, 1'b0, 1'b1, 1'b0, 1'b0},
        '{24'h000000, 5'd26, 1'b0, 1'b1, 1'b0, 1'b0},
        '{24'h800000, 5'd26, 1'b0, 1'b1, 1'b0, 1'b0},
        '{24'h123456, 5'd25, 1'b0, 1'b0, 1'b1, 1'b0},
        '{24'hABCDEF, 5'd26, 1'b0, 1'b1, 1'b0, 1'b0},
        '{24'h7FFFFF, 5'd27, 1'b0, 1'b0, 1'b1, 1'b0},
        '{24'hA5C3E1, 5'd26, 1'b1, 1'b0, 1'b0, 1'b1},
        '{24'h0F0F0F, 5'd26, 1'b0, 1'b1, 1'b0, 1'b0},
        '{24'hC00001, 5'd26, 1'b0, 1'b1, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        sdat = 1'b0;
    logic        dir = 1'b0;
    wire  [23:0] par;
    logic        oe, valid, len_err, bnd_err;
    int          nchk = 0;
    int          nfail = 0;
    logic [23:0] held = 24'h0;

    always #10 clk = ~clk;

    ewb_deser #(.HI_LIMIT(LIM)) dut (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_dat_i(sdat),
        .dir_i(dir), .par_o(par), .par_oe_o(oe), .word_valid_o(valid),
        .len_err_o(len_err), .bnd_err_o(bnd_err)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Send n bits LSB first; bit mid_idx gets a high phase of mid_hi,
    // the last bit a high phase of last_hi. Ends with the clock falling.
    task automatic send_frame(input logic [23:0] d, input int n, input bit bad,
                              input int mid_idx, input int mid_hi, input int last_hi);
        logic [26:0] bits;
        bits = {1'b0, d[23], ~d[23], d};
        if (bad) bits[24] = ~bits[24];
        for (int i = 0; i < n; i++) begin
            sclk = 1'b0;
            sdat = bits[i];
            repeat (LO) @(negedge clk);
            sclk = 1'b1;
            if (i == n - 1)        repeat (last_hi) @(negedge clk);
            else if (i == mid_idx) repeat (mid_hi) @(negedge clk);
            else                   repeat (HI) @(negedge clk);
        end
        sclk = 1'b0;
    endtask

    // Check frame results at the R4 timing after the final clock fall.
    task automatic check_after(input bit ev, input bit el, input bit eb,
                               input logic [23:0] d, input string req);
        @(negedge clk);
        @(negedge clk);
        chk(valid == 1'b0, {req, " R4 early strobe"}, 32'(valid), 0);
        @(negedge clk);
        chk(valid == ev,   {req, " R4 strobe"}, 32'(valid), 32'(ev));
        chk(len_err == el, {req, " R6 len_err"}, 32'(len_err), 32'(el));
        chk(bnd_err == eb, {req, " R7 bnd_err"}, 32'(bnd_err), 32'(eb));
        if (ev) held = d;
        if (!dir) chk(par === held, {req, " R2 R5 word"}, 32'(par), 32'(held));
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(valid == 1'b0 && len_err == 1'b0 && bnd_err == 1'b0, "R1 flags in reset",
            {29'd0, valid, len_err, bnd_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(par === 24'h0, "R1 word after reset", 32'(par), 0);
        chk(oe == 1'b1, "R10 oe with dir low", 32'(oe), 1);

        // R9: first frame only aligns, even with a wrong length
        send_frame(24'h00BEEF, 20, 1'b0, -1, HI, LONG);
        check_after(1'b0, 1'b0, 1'b0, 24'h0, "R9 first frame");

        // Table of frames: normal, wrong length, bad boundary, resync (R8)
        for (int i = 0; i < 10; i++) begin
            send_frame(VECS[i].data, int'(VECS[i].nbits), VECS[i].bad, -1, HI, LONG);
            check_after(VECS[i].e_valid, VECS[i].e_len, VECS[i].e_bnd,
                        VECS[i].data, "R2 R6 R7 R8 table");
        end

        // R3: a high phase of exactly the limit is an ordinary bit
        send_frame(24'h3C3C3C, 26, 1'b0, 5, LIM, LONG);
        check_after(1'b1, 1'b0, 1'b0, 24'h3C3C3C, "R3 limit not boundary");

        // R3: one cycle over the limit is a boundary (here after 5 bits)
        send_frame(24'h111111, 5, 1'b0, -1, HI, LIM + 1);
        check_after(1'b0, 1'b1, 1'b0, 24'h0, "R3 R6 over limit");

        // R8: recovery after that error
        send_frame(24'h9A8B7C, 26, 1'b0, -1, HI, LONG);
        check_after(1'b1, 1'b0, 1'b0, 24'h9A8B7C, "R8 resync");

        // R10: port released while dir high, word captured meanwhile
        dir = 1'b1;
        @(negedge clk);
        chk(oe == 1'b0, "R10 oe with dir high", 32'(oe), 0);
        send_frame(24'h13579B, 26, 1'b0, -1, HI, LONG);
        check_after(1'b1, 1'b0, 1'b0, 24'h13579B, "R10 capture while released");
        dir = 1'b0;
        @(negedge clk);
        chk(oe == 1'b1, "R10 oe restored", 32'(oe), 1);
        chk(par === 24'h13579B, "R10 word shown", 32'(par), 32'h13579B);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule